// File: doc/BRIEF.md
# Split-Toeplitz GF(2^m) Hash Accumulator

This block computes a polynomial-evaluation hash over GF(2^m), the authentication hash used in counter-mode authenticated encryption. Once a hash key H has been loaded, a stream of m-bit blocks C1..Cn is folded into a running value V. The first block is copied into V. Each later block updates V to H·V + Ci. After the last block, one more multiply by H gives the tag. Only one field multiply is done per clock, so a message of n blocks costs n+1 cycles.

The multiply by H is not a schoolbook array. The reduced m×m matrix of "multiply by H modulo x^m + e(x)" is written as a Toeplitz matrix T plus a correction S, and S has nonzero entries only in its top δ rows, where δ = deg e. The Toeplitz product T·V is computed by the recursive two-way split, which uses three half-size products per level. This gives 3^log2(m) AND terms. Each of the δ correction rows is a dot product with V, and it is XORed back into the result.

Everything that depends only on H is prepared once for each key. This covers the Toeplitz diagonals, the recursive component operands of T, and the S rows. A serial scan produces one matrix column per cycle, and a finishing cycle then stores the components in registers.

The controller is a state machine with six states:
- IDLE: no key has been loaded.
- KSCAN: one matrix column is generated per cycle.
- KFIN: the components and correction rows are stored.
- WAIT: the block is ready and waits for a start block.
- ACCUM: a message is in progress.
- FINAL: the extra multiply is done.

The transitions are:
- any state to KSCAN on a key load;
- KSCAN to KFIN after the last column;
- KFIN to WAIT;
- WAIT to ACCUM on a start block, or to FINAL on a start block that is also last;
- ACCUM to FINAL on a last block;
- FINAL to WAIT.

Top module: `ghash_tsplit_mac`

## Requirements
- R1: After reset, key_ready, tag_done and tag_out are all 0.
- R2: A key_load pulse clears tag_out to 0, drops key_ready in the next cycle, and aborts any message in progress. key_ready returns high exactly M+1 cycles after the clock edge that sampled key_load.
- R3: A single block that has both blk_start and blk_last gives the tag C1·H mod (x^M + E_POLY), where bit i of a word is the coefficient of x^i.
- R4: A message of n blocks gives V = C1, then V = H·V + Ck for k = 2..n, then V = H·V. The tag is this final V.
- R5: tag_done is a one-cycle pulse. It is high in the second cycle after the clock edge that samples the last block. tag_out holds the tag until the next accepted start block or key load.
- R6: A valid block is ignored when there is no key (IDLE), during key preparation, and in WAIT when blk_start is low. "Ignored" means that tag_out does not change and the next message's tag is not affected.
- R7: Cycles with blk_valid low inside a message have no effect on the tag.
- R8: A block with blk_start high during a message in progress discards the old value and starts a new message with V = that block.
- R9: A block presented in the cycle of the final multiply (the cycle after the last block is sampled) is ignored.
- R10: The reduction is modulo x^M + E_POLY with δ = deg(E_POLY) ≥ 1. The following keys must give the results shown:

  | Key | Expected tag |
  |-----|--------------|
  | H = 0 | 0 |
  | H = 1 | the XOR of all the blocks |
  | H = x^(M-1) | correctly reduced |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Pulse to capture key_in and start key preparation |
| key_in | input | M | Hash key H |
| blk_valid | input | 1 | Qualifies blk_data, blk_start and blk_last |
| blk_start | input | 1 | Marks the first block of a message |
| blk_last | input | 1 | Marks the final block of a message |
| blk_data | input | M | Data block Ci |
| key_ready | output | 1 | High when key preparation is finished and blocks are accepted |
| tag_out | output | M | Running value; holds the tag after tag_done |
| tag_done | output | 1 | One-cycle pulse when the tag is valid |

## Verification
The assertions assume three things about the inputs:
- key_load is driven from a known value every cycle;
- blk_valid is a known level;
- the key-preparation length is counted only from the most recent key_load.

The stimulus respects these assumptions. It changes every input only on the falling clock edge. It sends message blocks only after key_ready is seen high. The stray blocks (in IDLE, in WAIT without a start, and in the final-multiply cycle) are placed on purpose in the exact cycles where the design must ignore them.

// File: rtl/ghx_pkg.sv
package ghx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_KSCAN = 3'd1,
        ST_KFIN  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_ACCUM = 3'd4,
        ST_FINAL = 3'd5
    } ghx_state_e;

    // ceil(log2(n)) for n >= 1
    function automatic int log2c(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    function automatic int pow3(input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) r = r * 3;
        return r;
    endfunction

endpackage

// File: rtl/ghx_key_scan.sv
// Serial key preparation: walks column j = H*x^j mod f, one column per cycle,
// recording the Toeplitz diagonals from rows >= D and the raw top D rows.
module ghx_key_scan #(
    parameter int           M      = 32,
    parameter int           D      = 7,
    parameter logic [M-1:0] E_POLY = 32'h0000_008D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [M-1:0]     key,
    input  logic             step,
    output logic             last,
    output logic [2*M-2:0]   diag,
    output logic [D*M-1:0]   top
);
    localparam int IW = (ghx_pkg::log2c(M) < 1) ? 1 : ghx_pkg::log2c(M);

    logic [M-1:0]   col_q;
    logic [IW-1:0]  idx_q;
    logic [2*M-2:0] diag_q;
    logic [D*M-1:0] top_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            idx_q  <= '0;
            diag_q <= '0;
            top_q  <= '0;
        end else if (start) begin
            col_q  <= key;
            idx_q  <= '0;
            diag_q <= '0;
            top_q  <= '0;
        end else if (step) begin
            for (int i = 0; i < M; i++) begin
                if (i >= D)
                    diag_q[i - int'(idx_q) + M - 1] <= col_q[i];
                else
                    top_q[i*M + int'(idx_q)] <= col_q[i];
            end
            col_q <= {col_q[M-2:0], 1'b0} ^ (col_q[M-1] ? E_POLY : '0);
            idx_q <= idx_q + 1'b1;
        end
    end

    assign last = (idx_q == IW'(M-1));
    assign diag = diag_q;
    assign top  = top_q;

endmodule

// File: rtl/ghx_comp_form.sv
// Recursive component formation of an N x N Toeplitz matrix given by its
// 2N-1 diagonals (index = row - col + N - 1). Output holds 3^log2(N) bits.
module ghx_comp_form #(
    parameter int N = 32
) (
    input  logic [2*N-2:0] diag,
    output logic [ghx_pkg::pow3(ghx_pkg::log2c(N))-1:0] comp
);
    localparam int NC = ghx_pkg::pow3(ghx_pkg::log2c(N));

    generate
        if (N == 1) begin : g_leaf
            assign comp = diag;
        end else begin : g_split
            localparam int H  = N / 2;
            localparam int HC = NC / 3;
            logic [2*H-2:0] sub0, sub1, sub2;

            assign sub1 = diag[H +: 2*H-1];
            assign sub0 = diag[0 +: 2*H-1] ^ sub1;
            assign sub2 = diag[2*H +: 2*H-1] ^ sub1;

            ghx_comp_form #(.N(H)) u_c0 (.diag(sub0), .comp(comp[0    +: HC]));
            ghx_comp_form #(.N(H)) u_c1 (.diag(sub1), .comp(comp[HC   +: HC]));
            ghx_comp_form #(.N(H)) u_c2 (.diag(sub2), .comp(comp[2*HC +: HC]));
        end
    endgenerate

endmodule

// File: rtl/ghx_tsplit_mul.sv
// Recursive Toeplitz matrix-vector product from precomputed components:
// vector formation, AND with the components and reconstruction.
module ghx_tsplit_mul #(
    parameter int N = 32
) (
    input  logic [ghx_pkg::pow3(ghx_pkg::log2c(N))-1:0] comp,
    input  logic [N-1:0] vec,
    output logic [N-1:0] res
);
    localparam int NC = ghx_pkg::pow3(ghx_pkg::log2c(N));

    generate
        if (N == 1) begin : g_leaf
            assign res = comp & vec;
        end else begin : g_split
            localparam int H  = N / 2;
            localparam int HC = NC / 3;
            logic [H-1:0] lo, hi, p0, p1, p2;

            assign lo = vec[H-1:0];
            assign hi = vec[N-1:H];

            ghx_tsplit_mul #(.N(H)) u_m0 (.comp(comp[0    +: HC]), .vec(hi),      .res(p0));
            ghx_tsplit_mul #(.N(H)) u_m1 (.comp(comp[HC   +: HC]), .vec(lo ^ hi), .res(p1));
            ghx_tsplit_mul #(.N(H)) u_m2 (.comp(comp[2*HC +: HC]), .vec(lo),      .res(p2));

            assign res = {p2 ^ p1, p0 ^ p1};
        end
    endgenerate

endmodule

// File: rtl/ghx_row_dot.sv
// D correction rows, each an AND array followed by an XOR tree; rows D..M-1 are 0.
module ghx_row_dot #(
    parameter int M = 32,
    parameter int D = 7
) (
    input  logic [D*M-1:0] rows,
    input  logic [M-1:0]   vec,
    output logic [M-1:0]   res
);
    generate
        for (genvar i = 0; i < M; i++) begin : g_row
            if (i < D) begin : g_dot
                assign res[i] = ^(rows[i*M +: M] & vec);
            end else begin : g_zero
                assign res[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/ghash_tsplit_mac.sv
module ghash_tsplit_mac #(
    parameter int           M      = 32,
    parameter logic [M-1:0] E_POLY = 32'h0000_008D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_load,
    input  logic [M-1:0] key_in,
    input  logic         blk_valid,
    input  logic         blk_start,
    input  logic         blk_last,
    input  logic [M-1:0] blk_data,
    output logic         key_ready,
    output logic [M-1:0] tag_out,
    output logic         tag_done
);
    import ghx_pkg::*;

    function automatic int deg_of(input logic [M-1:0] p);
        int d;
        d = 0;
        for (int i = 0; i < M; i++) if (p[i]) d = i;
        return d;
    endfunction

    localparam int D  = deg_of(E_POLY);
    localparam int NC = pow3(log2c(M));

    ghx_state_e state, state_nx;

    logic [2*M-2:0] diag_w;
    logic [D*M-1:0] top_w;
    logic [D*M-1:0] s_w;
    logic [NC-1:0]  cmf_w;
    logic [NC-1:0]  cmf_q;
    logic [D*M-1:0] srow_q;
    logic [M-1:0]   v_q;
    logic           done_q;
    logic           scan_last;
    logic [M-1:0]   t_prod, s_prod, hv;

    // key preparation
    ghx_key_scan #(.M(M), .D(D), .E_POLY(E_POLY)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (key_load),
        .key   (key_in),
        .step  (state == ST_KSCAN),
        .last  (scan_last),
        .diag  (diag_w),
        .top   (top_w)
    );

    ghx_comp_form #(.N(M)) u_cmf (.diag(diag_w), .comp(cmf_w));

    // correction rows = full top rows minus their Toeplitz part
    always_comb begin
        for (int i = 0; i < D; i++)
            for (int j = 0; j < M; j++)
                s_w[i*M + j] = top_w[i*M + j] ^ diag_w[i - j + M - 1];
    end

    // multiply by H: Toeplitz part plus correction rows
    ghx_tsplit_mul #(.N(M)) u_tmul (.comp(cmf_q), .vec(v_q), .res(t_prod));
    ghx_row_dot #(.M(M), .D(D)) u_rows (.rows(srow_q), .vec(v_q), .res(s_prod));

    assign hv = t_prod ^ s_prod;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (key_load) begin
            state_nx = ST_KSCAN;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_KSCAN: if (scan_last) state_nx = ST_KFIN;
                ST_KFIN:  state_nx = ST_WAIT;
                ST_WAIT:  if (blk_valid && blk_start)
                              state_nx = blk_last ? ST_FINAL : ST_ACCUM;
                ST_ACCUM: if (blk_valid && blk_last) state_nx = ST_FINAL;
                ST_FINAL: state_nx = ST_WAIT;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmf_q  <= '0;
            srow_q <= '0;
            v_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (key_load) begin
                v_q <= '0;
            end else begin
                unique case (state)
                    ST_KFIN: begin
                        cmf_q  <= cmf_w;
                        srow_q <= s_w;
                    end
                    ST_WAIT: if (blk_valid && blk_start) v_q <= blk_data;
                    ST_ACCUM: if (blk_valid)
                        v_q <= blk_start ? blk_data : (hv ^ blk_data);
                    ST_FINAL: begin
                        v_q    <= hv;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign key_ready = (state == ST_WAIT) || (state == ST_ACCUM) || (state == ST_FINAL);
    assign tag_out   = v_q;
    assign tag_done  = done_q;

endmodule

// File: rtl/ghx_check.sv
module ghx_check #(
    parameter int M = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_load,
    input  logic               blk_valid,
    input  logic               blk_start,
    input  logic               key_ready,
    input  logic               tag_done,
    input  logic [M-1:0]       tag_out,
    input  ghx_pkg::ghx_state_e state
);
    import ghx_pkg::*;

    logic [15:0] since_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_load <= '0;
        else if (key_load)          since_load <= 16'd1;
        else if (since_load != '1)  since_load <= since_load + 16'd1;
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tag_done |=> !tag_done);

    a_r5_done_with_key: assert property (@(posedge clk) disable iff (!rst_n)
        tag_done |-> key_ready);

    a_r5_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_done && !blk_valid && !key_load) |=> $stable(tag_out));

    a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> (!key_ready && tag_out == '0));

    a_r2_prep_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_ready) |-> (since_load == 16'(M + 2)));

    a_r6_stray_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && blk_valid && !blk_start && !key_load)
        |=> (state == ST_WAIT && $stable(tag_out)));

    a_r9_final_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL && !key_load) |=> (state == ST_WAIT && tag_done));

endmodule

bind ghash_tsplit_mac ghx_check #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_load  (key_load),
    .blk_valid (blk_valid),
    .blk_start (blk_start),
    .key_ready (key_ready),
    .tag_done  (tag_done),
    .tag_out   (tag_out),
    .state     (state)
);

// File: tb/sim_ghash_tsplit_mac.sv
`timescale 1ns/1ps
module sim_ghash_tsplit_mac;
    localparam int           M    = 32;
    localparam logic [M-1:0] EPOL = 32'h0000_008D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [M-1:0] key_in = '0;
    logic         blk_valid = 1'b0;
    logic         blk_start = 1'b0;
    logic         blk_last = 1'b0;
    logic [M-1:0] blk_data = '0;
    logic         key_ready;
    logic [M-1:0] tag_out;
    logic         tag_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [M-1:0] msg [0:15];

    always #5 clk = ~clk;

    ghash_tsplit_mac #(.M(M), .E_POLY(EPOL)) u0 (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .blk_valid(blk_valid), .blk_start(blk_start), .blk_last(blk_last),
        .blk_data(blk_data), .key_ready(key_ready), .tag_out(tag_out),
        .tag_done(tag_done)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? EPOL : '0);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] ghash_ref(input logic [M-1:0] h, input int n);
        logic [M-1:0] v;
        v = msg[0];
        for (int k = 1; k < n; k++) v = gf_mul(h, v) ^ msg[k];
        return gf_mul(h, v);
    endfunction

    task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                         input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_key(input logic [M-1:0] h);
        int cnt;
        @(negedge clk);
        key_load = 1'b1;
        key_in   = h;
        blk_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        key_load = 1'b0;
        check(!key_ready, "R2 ready drop", M'(key_ready), '0);
        check(tag_out == '0, "R2 tag cleared", tag_out, '0);
        cnt = 0;
        while (!key_ready && cnt < 1000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        check(cnt == M + 1, "R2 prep length", M'(cnt), M'(M + 1));
    endtask

    // sends msg[0..n-1]; caller is at a negedge or just after reset
    task automatic run_msg(input int n, input logic [M-1:0] h, input bit gaps,
                           input bit junk, input string req);
        logic [M-1:0] exp;
        exp = ghash_ref(h, n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            blk_valid = 1'b1;
            blk_start = (k == 0);
            blk_last  = (k == n - 1);
            blk_data  = msg[k];
            @(posedge clk);
            if (gaps && k < n - 1 && ($urandom % 2 == 0)) begin
                @(negedge clk);
                blk_valid = 1'b0;
                blk_start = 1'b1;
                blk_last  = 1'b1;
                blk_data  = $urandom;
                @(posedge clk);
            end
        end
        @(negedge clk);
        if (junk) begin
            blk_valid = 1'b1;
            blk_start = 1'b0;
            blk_last  = 1'b1;
            blk_data  = $urandom;
        end else begin
            blk_valid = 1'b0;
        end
        check(!tag_done, {req, " R5 no early done"}, M'(tag_done), '0);
        @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        blk_start = 1'b0;
        blk_last  = 1'b0;
        check(tag_done, {req, " R5 done pulse"}, M'(tag_done), M'(1));
        check(tag_out == exp, req, tag_out, exp);
        @(posedge clk);
        @(negedge clk);
        check(!tag_done, "R5 done one cycle", M'(tag_done), '0);
        check(tag_out == exp, "R5 tag hold", tag_out, exp);
    endtask

    task automatic fill_rand(input int n);
        for (int k = 0; k < n; k++) msg[k] = $urandom;
    endtask

    initial begin
        logic [M-1:0] h, acc, prev;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!key_ready, "R1 key_ready", M'(key_ready), '0);
        check(!tag_done, "R1 tag_done", M'(tag_done), '0);
        check(tag_out == '0, "R1 tag_out", tag_out, '0);

        // R6 block without a key is ignored
        blk_valid = 1'b1; blk_start = 1'b1; blk_last = 1'b1; blk_data = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        check(tag_out == '0 && !tag_done, "R6 idle ignored", tag_out, '0);

        // R2 key preparation
        h = $urandom;
        do_key(h);

        // R3 single block
        msg[0] = $urandom;
        run_msg(1, h, 1'b0, 1'b0, "R3 single");
        msg[0] = '1;
        run_msg(1, h, 1'b0, 1'b0, "R3 all ones");

        // R4 random messages, R7 gaps, R9 junk in final cycle
        for (int t = 0; t < 8; t++) begin
            int n;
            n = 2 + int'($urandom % 7);
            fill_rand(n);
            run_msg(n, h, t[0], 1'b0, (t[0] ? "R7 gaps" : "R4 multi"));
        end
        fill_rand(5);
        run_msg(5, h, 1'b0, 1'b1, "R9 final junk");
        fill_rand(3);
        run_msg(3, h, 1'b1, 1'b1, "R9 final junk gaps");

        // R6 stray block in WAIT without start
        prev = tag_out;
        @(negedge clk);
        blk_valid = 1'b1; blk_start = 1'b0; blk_last = 1'b1; blk_data = $urandom;
        @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        check(tag_out == prev && !tag_done, "R6 stray in wait", tag_out, prev);
        msg[0] = $urandom;
        run_msg(1, h, 1'b0, 1'b0, "R6 after stray");

        // R8 restart inside a message
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            blk_valid = 1'b1; blk_start = (k == 0); blk_last = 1'b0; blk_data = $urandom;
            @(posedge clk);
        end
        fill_rand(4);
        run_msg(4, h, 1'b0, 1'b0, "R8 restart");

        // R2 key reload aborts a message
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            blk_valid = 1'b1; blk_start = (k == 0); blk_last = 1'b0; blk_data = $urandom;
            @(posedge clk);
        end
        h = $urandom | 32'h8000_0000;
        do_key(h);
        check(!tag_done, "R2 no done after abort", M'(tag_done), '0);
        fill_rand(6);
        run_msg(6, h, 1'b0, 1'b0, "R2 new key");

        // R10 special keys
        do_key('0);
        fill_rand(4);
        run_msg(4, '0, 1'b0, 1'b0, "R10 zero key");
        check(tag_out == '0, "R10 zero tag", tag_out, '0);
        do_key(32'h1);
        fill_rand(5);
        acc = '0;
        for (int k = 0; k < 5; k++) acc = acc ^ msg[k];
        run_msg(5, 32'h1, 1'b0, 1'b0, "R10 unit key");
        check(tag_out == acc, "R10 unit xor", tag_out, acc);
        do_key(32'h8000_0000);
        msg[0] = 32'hFFFF_FFFF; msg[1] = 32'h8000_0001; msg[2] = 32'h7FFF_FFFE;
        run_msg(3, 32'h8000_0000, 1'b0, 1'b0, "R10 top key");

        summary();
        $finish;
    end

endmodule